// File: doc/BRIEF.md
# Byte-Stream Memory Command Decoder

The block sits between a host byte channel and a controller for a banked DRAM-style memory. It reads a command as a sequence of bytes: an opcode, three address bytes and, for a write, four data bytes. Once the whole command has arrived, it runs four single-byte memory accesses. It then sends an eight-byte reply. Both byte channels use valid/ready handshakes. The memory port is a request held until acknowledged, one byte per beat.

The 13-bit row address spans the command. Its top bit is bit 0 of the opcode byte. The four beats of an access stay inside the aligned group of four columns that holds the start column. Only the two lowest column bits advance, so they wrap modulo 4. When the memory reports itself uninitialised, no access takes place and the reply carries an error code in the opcode slot.

Top module: `memcmd_decoder`

## Requirements
- R1: An opcode byte with upper nibble 0x8 starts a read and one with upper nibble 0x9 starts a write. Bit 0 of the opcode is row bit 12 (the most significant row bit).
- R2: Field mapping:
  - Address byte 1 is row[11:4].
  - Address byte 2 bits 7:4 are row[3:0], and its bits 3:0 are col[9:6].
  - Address byte 3 bits 7:2 are col[5:0], and its bits 1:0 are the bank.
- R3: A write takes exactly four data bytes after the address bytes. No memory request is raised before the last byte of the command has been accepted.
- R4: Beat i (i = 0..3) of an access uses column {start[9:2], (start[1:0]+i) mod 4}, with the same bank and row. For a write, beat i stores data byte i.
- R5: A successful read replies with the four bytes read, in beat order, starting at the addressed column.
- R6: Every reply is eight bytes long:
  - bytes 0 to 3 are data (for a write, the bytes written);
  - byte 4 is the opcode byte;
  - bytes 5 to 7 are the three address bytes in the order received.
- R7: If the memory-initialised input is low when the last command byte is accepted, no memory request is made and reply byte 4 is 0xE7. For a read, reply bytes 0 to 3 are 0x00.
- R8: When idle, a byte whose upper nibble is neither 0x8 nor 0x9 is consumed and discarded, and the block stays idle.
- R9: While a reply byte is offered and not taken, the byte is held stable. No input byte is accepted from the moment a command is complete until its reply has been fully sent.
- R10: A memory request and its fields stay stable until the cycle in which it is acknowledged.
- R11: A synchronous active-high reset returns the block to idle, with no reply or request pending, and discards a partly received command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte offered |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Host byte accepted when valid |
| mem_init | input | 1 | Memory initialised |
| rsp_valid | output | 1 | Reply byte offered |
| rsp_data | output | 8 | Reply byte |
| rsp_ready | input | 1 | Reply byte taken |
| req_valid | output | 1 | Memory beat requested |
| req_write | output | 1 | Beat is a write |
| req_bank | output | 2 | Bank number |
| req_row | output | 13 | Row address |
| req_col | output | 10 | Column of this beat |
| req_wdata | output | 8 | Byte to store |
| req_ack | input | 1 | Beat done |
| req_rdata | input | 8 | Byte read, valid with req_ack |

## Verification
The bench first writes an aligned group and reads it back. It then writes from an unaligned column and reads again from the aligned start. This separates true modulo-4 wrapping from a plain increment and shows that the unaligned write overwrites the earlier one. A write and read with opcode bit 0 set, to bank 3, from a start column of 2, checks the row and bank placement against the aligned case. Further cases cover junk bytes before a command, commands with the memory uninitialised followed by a read-back that shows nothing was written, and a reset in the middle of a command. Reply back-pressure and memory acknowledge stalls vary throughout.

// File: rtl/memcmd_decoder.sv
module memcmd_decoder #(
  parameter logic [7:0] ERR_CODE = 8'hE7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic        mem_init,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        rsp_ready,
  output logic        req_valid,
  output logic        req_write,
  output logic [1:0]  req_bank,
  output logic [12:0] req_row,
  output logic [9:0]  req_col,
  output logic [7:0]  req_wdata,
  input  logic        req_ack,
  input  logic [7:0]  req_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_MEM, S_REPLY} state_t;

  state_t          st;
  logic [7:0]      op_q;
  logic [23:0]     addr_q;
  logic [3:0][7:0] data_q;
  logic [2:0]      cnt;
  logic            err_q;

  wire take  = in_valid && in_ready;
  wire is_wr = op_q[4];
  wire opc   = (in_data[7:4] == 4'h8) || (in_data[7:4] == 4'h9);

  assign in_ready  = (st == S_IDLE) || (st == S_ADDR) || (st == S_DATA);
  assign req_valid = (st == S_MEM);
  assign req_write = is_wr;
  assign req_row   = {op_q[0], addr_q[23:16], addr_q[15:12]};
  assign req_col   = {addr_q[11:8], addr_q[7:4], addr_q[3:2] + cnt[1:0]};
  assign req_bank  = addr_q[1:0];
  assign req_wdata = data_q[cnt[1:0]];
  assign rsp_valid = (st == S_REPLY);

  always_comb begin
    if (!cnt[2]) rsp_data = data_q[cnt[1:0]];
    else begin
      case (cnt[1:0])
        2'd0:    rsp_data = err_q ? ERR_CODE : op_q;
        2'd1:    rsp_data = addr_q[23:16];
        2'd2:    rsp_data = addr_q[15:8];
        default: rsp_data = addr_q[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      err_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (take && opc) begin
          op_q <= in_data;
          cnt  <= '0;
          st   <= S_ADDR;
        end
        S_ADDR: if (take) begin
          addr_q <= {addr_q[15:0], in_data};
          if (cnt == 3'd2) begin
            cnt <= '0;
            if (is_wr) st <= S_DATA;
            else begin
              err_q <= !mem_init;
              if (!mem_init) begin
                data_q <= '0;
                st     <= S_REPLY;
              end else st <= S_MEM;
            end
          end else cnt <= cnt + 3'd1;
        end
        S_DATA: if (take) begin
          data_q[cnt[1:0]] <= in_data;
          if (cnt == 3'd3) begin
            cnt   <= '0;
            err_q <= !mem_init;
            st    <= mem_init ? S_MEM : S_REPLY;
          end else cnt <= cnt + 3'd1;
        end
        S_MEM: if (req_ack) begin
          if (!is_wr) data_q[cnt[1:0]] <= req_rdata;
          if (cnt == 3'd3) begin
            cnt <= '0;
            st  <= S_REPLY;
          end else cnt <= cnt + 3'd1;
        end
        S_REPLY: if (rsp_ready) begin
          if (cnt == 3'd7) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else cnt <= cnt + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memcmd_decoder_chk.sv
module memcmd_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        in_ready,
  input logic        mem_init,
  input logic        rsp_valid,
  input logic [7:0]  rsp_data,
  input logic        rsp_ready,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_bank,
  input logic [12:0] req_row,
  input logic [9:0]  req_col,
  input logic [7:0]  req_wdata,
  input logic        req_ack,
  input logic [7:0]  req_rdata
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ack |=> req_valid && $stable(req_col) && $stable(req_row)
      && $stable(req_bank) && $stable(req_write) && $stable(req_wdata));

  // R4
  col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ack |=> !req_valid ||
      (req_col[1:0] == $past(req_col[1:0]) + 2'd1 && req_col[9:2] == $past(req_col[9:2])
       && $stable(req_row) && $stable(req_bank)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R9
  reply_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !in_ready);

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !in_ready && !rsp_valid);
endmodule

bind memcmd_decoder memcmd_decoder_chk u_chk (.*);

// File: tb/tb_memcmd_decoder.sv
module tb_memcmd_decoder;
  logic clk = 0, rst = 1;
  logic in_valid = 0; logic [7:0] in_data = 0; logic in_ready;
  logic mem_init = 1;
  logic rsp_valid; logic [7:0] rsp_data; logic rsp_ready = 0;
  logic req_valid, req_write; logic [1:0] req_bank; logic [12:0] req_row;
  logic [9:0] req_col; logic [7:0] req_wdata;
  logic req_ack = 0; logic [7:0] req_rdata = 0;

  always #10 clk = ~clk;

  memcmd_decoder dut (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [7:0] exp_b[$]; string exp_t[$];
  int ex_key[$]; bit ex_wr[$]; logic [7:0] ex_wd[$];
  logic [7:0] mem[int]; logic [7:0] shadow[int];

  function automatic logic [7:0] dflt(int k);
    return k[7:0] ^ 8'h3C;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = lfsr[0] | lfsr[2];
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_b.size() == 0) check("R6 extra reply byte", rsp_data, 32'hFFFF);
      else begin
        check(exp_t[0], rsp_data, exp_b[0]);
        void'(exp_b.pop_front()); void'(exp_t.pop_front());
      end
    end
  end

  bit stall = 0;
  always @(negedge clk) begin
    if (req_ack) req_ack = 0;
    else if (!rst && req_valid && stall) begin
      automatic int k = {req_bank, req_row, req_col};
      if (ex_key.size() == 0) check("R7 unexpected request", k, 32'hFFFFFFFF);
      else begin
        check("R2 R4 request address", k, ex_key[0]);
        check("R1 request kind", req_write, ex_wr[0]);
        if (ex_wr[0]) check("R4 write byte", req_wdata, ex_wd[0]);
        void'(ex_key.pop_front()); void'(ex_wr.pop_front()); void'(ex_wd.pop_front());
      end
      if (req_write) mem[k] = req_wdata;
      req_rdata = mem.exists(k) ? mem[k] : dflt(k);
      req_ack = 1;
    end
    stall = ~stall;
  end

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3,
                     logic [31:0] d, bit init);
    automatic bit wr = op[4];
    automatic logic [12:0] row = {op[0], b1, b2[7:4]};
    automatic logic [9:0] cb = {b2[3:0], b3[7:2]};
    for (int i = 0; i < 4; i++) begin
      automatic logic [9:0] c = {cb[9:2], cb[1:0] + 2'(i)};
      automatic int k = {b3[1:0], row, c};
      automatic logic [7:0] db = d[8*i +: 8];
      automatic logic [7:0] rb;
      if (init) begin
        ex_key.push_back(k); ex_wr.push_back(wr); ex_wd.push_back(db);
        if (wr) shadow[k] = db;
        rb = wr ? db : (shadow.exists(k) ? shadow[k] : dflt(k));
      end else rb = wr ? db : 8'h00;
      exp_b.push_back(rb);
      exp_t.push_back(wr ? "R6 write data echo" : (init ? "R5 read data" : "R7 read data zero"));
    end
    exp_b.push_back(init ? op : 8'hE7);
    exp_t.push_back(init ? "R6 opcode echo" : "R7 error code");
    exp_b.push_back(b1); exp_t.push_back("R6 address echo 1");
    exp_b.push_back(b2); exp_t.push_back("R6 address echo 2");
    exp_b.push_back(b3); exp_t.push_back("R6 address echo 3");
    mem_init = init;
    send_byte(op); send_byte(b1); send_byte(b2); send_byte(b3);
    if (wr) for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8]);
  endtask

  task automatic drain;
    while (exp_b.size() != 0 || ex_key.size() != 0 || !in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid after reset", rsp_valid, 0);
    check("R11 req_valid after reset", req_valid, 0);
    check("R11 in_ready after reset", in_ready, 1);

    // R1 R2 R3 aligned write then read
    cmd(8'h90, 8'h12, 8'h34, 8'h00, 32'h44332211, 1);
    cmd(8'h80, 8'h12, 8'h34, 8'h00, 0, 1);
    // R4 unaligned write wraps and overwrites, read from aligned start
    cmd(8'h90, 8'h12, 8'h34, 8'h04, 32'hDDCCBBAA, 1);
    cmd(8'h80, 8'h12, 8'h34, 8'h00, 0, 1);
    // R1 R2 top row bit, bank 3, start column 2
    cmd(8'h91, 8'hA5, 8'hC7, 8'hBB, 32'h0F1E2D3C, 1);
    cmd(8'h81, 8'hA5, 8'hC7, 8'hBB, 0, 1);
    // R5 unwritten location
    cmd(8'h81, 8'h01, 8'h02, 8'h0D, 0, 1);
    drain();
    // R8 junk bytes dropped
    send_byte(8'h55); send_byte(8'h7F); send_byte(8'hF0); send_byte(8'hA3);
    @(negedge clk);
    check("R8 no reply after junk", rsp_valid, 0);
    check("R8 no request after junk", req_valid, 0);
    check("R8 still accepting", in_ready, 1);
    cmd(8'h80, 8'h12, 8'h34, 8'h08, 0, 1);
    // R7 not initialised: write and read, then read back shows no write
    cmd(8'h90, 8'h33, 8'h44, 8'h01, 32'h99887766, 0);
    cmd(8'h80, 8'h33, 8'h44, 8'h01, 0, 0);
    cmd(8'h80, 8'h33, 8'h44, 8'h01, 0, 1);
    drain();
    // R11 reset discards a partial command
    send_byte(8'h90); send_byte(8'h12); send_byte(8'h34);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R11 idle after mid-command reset", in_ready, 1);
    check("R11 no reply after mid-command reset", rsp_valid, 0);
    cmd(8'h80, 8'h12, 8'h34, 8'h00, 0, 1);
    drain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule